// File: doc/BRIEF.md
# Memory ECC Fault Injector

This block sits next to the write path of a memory controller and deliberately corrupts check bits so that the error-handling chain downstream can be exercised. Software programs a target through a small register port. The target has six address fields (channel, DIMM number within its channel, rank, bank, page and column). Each field carries its own compare-enable bit, so any field can be left as "match anything". Software also programs a check-bit mask, a section code, an error-kind word and an arm register.

When the block is armed and a write access matches every compare-enabled field, the block places the mask into the low half, the high half or both halves of a check-bit flip vector. The write path XORs this vector into the stored check bits. The block can also flag a parity disturbance per section. A repeat bit chooses between a single shot and continuous injection. A saturating counter records how many injections have been made.

Top module: `ecc_fault_injector`

## Requirements
- R1: After reset every register reads back zero: all match fields are in the match-any state (compare bit clear), the block is disarmed, the injection count is zero, and all outputs are zero.
- R2: Every register reads back what was written, limited to its width, on `cfgRdata` in the same cycle that `cfgAddr` selects it. The register addresses are: 0 channel, 1 DIMM, 2 rank, 3 bank, 4 page, 5 column, 6 check-bit mask, 7 section, 8 error kind, 9 arm, 10 injection count (read-only). Each match field register holds its value in the low bits and its compare-enable in bit 31.
- R3: A write access qualifies when every field that has its compare bit set equals the access field. A field with compare clear matches any value. A field compared against zero matches only zero.
- R4: Read accesses (`accWrite`=0) and cycles with `accValid`=0 never inject.
- R5: Section code 1 selects the low half (`ckFlip[ECC_W-1:0]`), 2 selects the high half, and 3 selects both. Code 0 selects nothing: no injection happens and the arm is kept.
- R6: Error-kind bit 1 requests a check-bit error, which puts the mask into `ckFlip`. Bit 2 requests a parity error, which sets `parFlip` to the section code. Bits combine. With neither bit set, no injection happens.
- R7: With kind bit 0 (repeat) clear, the block disarms itself after the first injection, and the arm register then reads 0.
- R8: With the repeat bit set, every qualifying write injects and the block stays armed.
- R9: Writing a nonzero value to the arm register arms the block, and writing zero disarms it. A disarmed block never injects.
- R10: Outputs change in the clock cycle after the qualifying access. They hold for exactly one cycle, marked by `injPulse`, and are zero in every other cycle.
- R11: The injection count at address 10 increments on each injection and saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register address |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data for `cfgAddr` |
| accValid | input | 1 | Memory access present this cycle |
| accWrite | input | 1 | Access is a write |
| accChannel | input | CH_W | Access channel |
| accDimm | input | DIMM_W | Access DIMM within channel |
| accRank | input | RANK_W | Access rank |
| accBank | input | BANK_W | Access bank |
| accPage | input | PAGE_W | Access page |
| accColumn | input | COL_W | Access column |
| ckFlip | output | 2*ECC_W | Check-bit flip vector |
| parFlip | output | 2 | Per-section parity flip |
| injPulse | output | 1 | One-cycle injection marker |

## Verification
A stuck or wrongly cleared arm bit appears at the ports on the next qualifying write: either a missing `injPulse` or an unexpected one, and a readback of the arm register shows it at once. A broken field comparator or wildcard shows up as a wrong hit or miss in the cycle after the access. A misplaced section shows as mask bits in the wrong half of `ckFlip`. Counter errors appear on the next readback of the count register, including after the count has been driven well past saturation.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  typedef enum logic [3:0] {
    RA_CHAN  = 4'd0,
    RA_DIMM  = 4'd1,
    RA_RANK  = 4'd2,
    RA_BANK  = 4'd3,
    RA_PAGE  = 4'd4,
    RA_COL   = 4'd5,
    RA_MASK  = 4'd6,
    RA_SECT  = 4'd7,
    RA_KIND  = 4'd8,
    RA_ARM   = 4'd9,
    RA_COUNT = 4'd10
  } regAddr_e;

  localparam int KIND_REPEAT = 0;
  localparam int KIND_ECC    = 1;
  localparam int KIND_PAR    = 2;
  localparam int CMP_BIT     = 31;

  // strobes handed from control to datapath
  typedef struct packed {
    logic       armed;
    logic       eccKind;
    logic       parKind;
    logic [1:0] section;
  } injCtrl_t;
endpackage

// File: rtl/ecc_inj_field.sv
module ecc_inj_field #(
  parameter int W = 4
) (
  input  logic         cmpEn,
  input  logic [W-1:0] val,
  input  logic [W-1:0] accVal,
  output logic         ok
);
  assign ok = !cmpEn || (val == accVal);
endmodule

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int ECC_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [3:0]        cfgAddr,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              hit,
  input  logic [CNT_W-1:0]  injCount,
  output injCtrl_t          ctrl,
  output logic [ECC_W-1:0]  eccMask,
  output logic              chCmp,
  output logic [CH_W-1:0]   chVal,
  output logic              dimmCmp,
  output logic [DIMM_W-1:0] dimmVal,
  output logic              rankCmp,
  output logic [RANK_W-1:0] rankVal,
  output logic              bankCmp,
  output logic [BANK_W-1:0] bankVal,
  output logic              pageCmp,
  output logic [PAGE_W-1:0] pageVal,
  output logic              colCmp,
  output logic [COL_W-1:0]  colVal
);
  logic [1:0] section;
  logic [2:0] kindBits;
  logic       armed;
  logic       armWrite;

  assign armWrite = cfgWe && (regAddr_e'(cfgAddr) == RA_ARM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chCmp <= 1'b0;   chVal   <= '0;
      dimmCmp <= 1'b0; dimmVal <= '0;
      rankCmp <= 1'b0; rankVal <= '0;
      bankCmp <= 1'b0; bankVal <= '0;
      pageCmp <= 1'b0; pageVal <= '0;
      colCmp <= 1'b0;  colVal  <= '0;
      eccMask  <= '0;
      section  <= '0;
      kindBits <= '0;
    end else if (cfgWe) begin
      case (regAddr_e'(cfgAddr))
        RA_CHAN: begin chCmp   <= cfgWdata[CMP_BIT]; chVal   <= cfgWdata[CH_W-1:0];   end
        RA_DIMM: begin dimmCmp <= cfgWdata[CMP_BIT]; dimmVal <= cfgWdata[DIMM_W-1:0]; end
        RA_RANK: begin rankCmp <= cfgWdata[CMP_BIT]; rankVal <= cfgWdata[RANK_W-1:0]; end
        RA_BANK: begin bankCmp <= cfgWdata[CMP_BIT]; bankVal <= cfgWdata[BANK_W-1:0]; end
        RA_PAGE: begin pageCmp <= cfgWdata[CMP_BIT]; pageVal <= cfgWdata[PAGE_W-1:0]; end
        RA_COL:  begin colCmp  <= cfgWdata[CMP_BIT]; colVal  <= cfgWdata[COL_W-1:0];  end
        RA_MASK: eccMask  <= cfgWdata[ECC_W-1:0];
        RA_SECT: section  <= cfgWdata[1:0];
        RA_KIND: kindBits <= cfgWdata[2:0];
        default: ;
      endcase
    end
  end

  // arm: software write wins over self-disarm in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)                           armed <= 1'b0;
    else if (armWrite)                   armed <= |cfgWdata;
    else if (hit && !kindBits[KIND_REPEAT]) armed <= 1'b0;
  end

  always_comb begin
    cfgRdata = '0;
    case (regAddr_e'(cfgAddr))
      RA_CHAN:  begin cfgRdata[CH_W-1:0]   = chVal;   cfgRdata[CMP_BIT] = chCmp;   end
      RA_DIMM:  begin cfgRdata[DIMM_W-1:0] = dimmVal; cfgRdata[CMP_BIT] = dimmCmp; end
      RA_RANK:  begin cfgRdata[RANK_W-1:0] = rankVal; cfgRdata[CMP_BIT] = rankCmp; end
      RA_BANK:  begin cfgRdata[BANK_W-1:0] = bankVal; cfgRdata[CMP_BIT] = bankCmp; end
      RA_PAGE:  begin cfgRdata[PAGE_W-1:0] = pageVal; cfgRdata[CMP_BIT] = pageCmp; end
      RA_COL:   begin cfgRdata[COL_W-1:0]  = colVal;  cfgRdata[CMP_BIT] = colCmp;  end
      RA_MASK:  cfgRdata[ECC_W-1:0] = eccMask;
      RA_SECT:  cfgRdata[1:0] = section;
      RA_KIND:  cfgRdata[2:0] = kindBits;
      RA_ARM:   cfgRdata[0] = armed;
      RA_COUNT: cfgRdata[CNT_W-1:0] = injCount;
      default:  cfgRdata = '0;
    endcase
  end

  assign ctrl.armed   = armed;
  assign ctrl.eccKind = kindBits[KIND_ECC];
  assign ctrl.parKind = kindBits[KIND_PAR];
  assign ctrl.section = section;

  // R7: a single-shot injection drops the arm
  p_oneshot_disarm_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !kindBits[KIND_REPEAT] && !armWrite) |=> !armed);

  // R8: repeat mode keeps the arm
  p_repeat_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hit && kindBits[KIND_REPEAT] && !armWrite) |=> armed);
endmodule

// File: rtl/ecc_inj_datapath.sv
module ecc_inj_datapath
  import ecc_inj_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int ECC_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  injCtrl_t          ctrl,
  input  logic [ECC_W-1:0]  eccMask,
  input  logic              chCmp,
  input  logic [CH_W-1:0]   chVal,
  input  logic              dimmCmp,
  input  logic [DIMM_W-1:0] dimmVal,
  input  logic              rankCmp,
  input  logic [RANK_W-1:0] rankVal,
  input  logic              bankCmp,
  input  logic [BANK_W-1:0] bankVal,
  input  logic              pageCmp,
  input  logic [PAGE_W-1:0] pageVal,
  input  logic              colCmp,
  input  logic [COL_W-1:0]  colVal,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [CH_W-1:0]   accChannel,
  input  logic [DIMM_W-1:0] accDimm,
  input  logic [RANK_W-1:0] accRank,
  input  logic [BANK_W-1:0] accBank,
  input  logic [PAGE_W-1:0] accPage,
  input  logic [COL_W-1:0]  accColumn,
  output logic              hit,
  output logic [2*ECC_W-1:0] ckFlip,
  output logic [1:0]        parFlip,
  output logic              injPulse,
  output logic [CNT_W-1:0]  injCount
);
  localparam int NFIELD = 6;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NFIELD-1:0]  fieldOk;
  logic [2*ECC_W-1:0] placed;

  ecc_inj_field #(.W(CH_W))   uChan (.cmpEn(chCmp),   .val(chVal),   .accVal(accChannel), .ok(fieldOk[0]));
  ecc_inj_field #(.W(DIMM_W)) uDimm (.cmpEn(dimmCmp), .val(dimmVal), .accVal(accDimm),    .ok(fieldOk[1]));
  ecc_inj_field #(.W(RANK_W)) uRank (.cmpEn(rankCmp), .val(rankVal), .accVal(accRank),    .ok(fieldOk[2]));
  ecc_inj_field #(.W(BANK_W)) uBank (.cmpEn(bankCmp), .val(bankVal), .accVal(accBank),    .ok(fieldOk[3]));
  ecc_inj_field #(.W(PAGE_W)) uPage (.cmpEn(pageCmp), .val(pageVal), .accVal(accPage),    .ok(fieldOk[4]));
  ecc_inj_field #(.W(COL_W))  uCol  (.cmpEn(colCmp),  .val(colVal),  .accVal(accColumn),  .ok(fieldOk[5]));

  assign hit = ctrl.armed && accValid && accWrite && (&fieldOk)
             && (ctrl.eccKind || ctrl.parKind) && (ctrl.section != 2'b00);

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign placed[h*ECC_W +: ECC_W] = ctrl.section[h] ? eccMask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      injPulse <= 1'b0;
      ckFlip   <= '0;
      parFlip  <= '0;
      injCount <= '0;
    end else begin
      injPulse <= hit;
      ckFlip   <= (hit && ctrl.eccKind) ? placed : '0;
      parFlip  <= (hit && ctrl.parKind) ? ctrl.section : 2'b00;
      if (hit && (injCount != CNT_MAX)) injCount <= injCount + 1'b1;
    end
  end

  // R10: outputs quiet outside an injection cycle
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !injPulse |-> (ckFlip == '0 && parFlip == 2'b00));

  // R9: an injection needs the arm from the control side
  p_pulse_needs_arm_r9: assert property (@(posedge clk) disable iff (!rstN)
    injPulse |-> $past(ctrl.armed));

  // R11: count holds at its ceiling
  p_count_sat_r11: assert property (@(posedge clk) disable iff (!rstN)
    (injCount == CNT_MAX) |=> (injCount == CNT_MAX));

  // R11: count steps by one on each injection below the ceiling
  p_count_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (injPulse && $past(injCount) != CNT_MAX) |-> (injCount == CNT_W'($past(injCount) + 1'b1)));
endmodule

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector
  import ecc_inj_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 10,
  parameter int ECC_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [3:0]         cfgAddr,
  input  logic [31:0]        cfgWdata,
  output logic [31:0]        cfgRdata,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic [CH_W-1:0]    accChannel,
  input  logic [DIMM_W-1:0]  accDimm,
  input  logic [RANK_W-1:0]  accRank,
  input  logic [BANK_W-1:0]  accBank,
  input  logic [PAGE_W-1:0]  accPage,
  input  logic [COL_W-1:0]   accColumn,
  output logic [2*ECC_W-1:0] ckFlip,
  output logic [1:0]         parFlip,
  output logic               injPulse
);
  injCtrl_t          ctrl;
  logic              hit;
  logic [CNT_W-1:0]  injCount;
  logic [ECC_W-1:0]  eccMask;
  logic              chCmp, dimmCmp, rankCmp, bankCmp, pageCmp, colCmp;
  logic [CH_W-1:0]   chVal;
  logic [DIMM_W-1:0] dimmVal;
  logic [RANK_W-1:0] rankVal;
  logic [BANK_W-1:0] bankVal;
  logic [PAGE_W-1:0] pageVal;
  logic [COL_W-1:0]  colVal;

  ecc_inj_ctrl #(
    .CH_W(CH_W), .DIMM_W(DIMM_W), .RANK_W(RANK_W), .BANK_W(BANK_W),
    .PAGE_W(PAGE_W), .COL_W(COL_W), .ECC_W(ECC_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk, .rstN, .cfgWe, .cfgAddr, .cfgWdata, .cfgRdata,
    .hit, .injCount, .ctrl, .eccMask,
    .chCmp, .chVal, .dimmCmp, .dimmVal, .rankCmp, .rankVal,
    .bankCmp, .bankVal, .pageCmp, .pageVal, .colCmp, .colVal
  );

  ecc_inj_datapath #(
    .CH_W(CH_W), .DIMM_W(DIMM_W), .RANK_W(RANK_W), .BANK_W(BANK_W),
    .PAGE_W(PAGE_W), .COL_W(COL_W), .ECC_W(ECC_W), .CNT_W(CNT_W)
  ) uDp (
    .clk, .rstN, .ctrl, .eccMask,
    .chCmp, .chVal, .dimmCmp, .dimmVal, .rankCmp, .rankVal,
    .bankCmp, .bankVal, .pageCmp, .pageVal, .colCmp, .colVal,
    .accValid, .accWrite, .accChannel, .accDimm, .accRank, .accBank,
    .accPage, .accColumn, .hit, .ckFlip, .parFlip, .injPulse, .injCount
  );
endmodule

// File: tb/ecc_fault_injector_test.sv
module ecc_fault_injector_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        accValid = 1'b0, accWrite = 1'b0;
  logic [1:0]  accChannel = '0, accDimm = '0, accRank = '0;
  logic [2:0]  accBank = '0;
  logic [15:0] accPage = '0;
  logic [9:0]  accColumn = '0;
  logic [15:0] ckFlip;
  logic [1:0]  parFlip;
  logic        injPulse;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_fault_injector uut (
    .clk, .rstN, .cfgWe, .cfgAddr, .cfgWdata, .cfgRdata,
    .accValid, .accWrite, .accChannel, .accDimm, .accRank, .accBank,
    .accPage, .accColumn, .ckFlip, .parFlip, .injPulse
  );

  // {write, ch, dimm, rank, bank, page, col, expHit}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 2'd2, 2'd1, 2'd0, 3'd5, 16'h00A5, 10'h3FF, 1'b1},
    {1'b1, 2'd2, 2'd3, 2'd0, 3'd0, 16'h00A5, 10'h000, 1'b1},
    {1'b1, 2'd1, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'h000, 1'b0},
    {1'b1, 2'd2, 2'd0, 2'd1, 3'd0, 16'h00A5, 10'h000, 1'b0},
    {1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A4, 10'h000, 1'b0},
    {1'b0, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'h000, 1'b0},
    {1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'h000, 1'b0},
    {1'b1, 2'd2, 2'd2, 2'd0, 3'd7, 16'h00A5, 10'h155, 1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  task automatic access(input logic w, input logic [1:0] ch, input logic [1:0] dm,
                        input logic [1:0] rk, input logic [2:0] bk, input logic [15:0] pg,
                        input logic [9:0] col, input logic expHit,
                        input logic [15:0] expCk, input logic [1:0] expPar, input string tag);
    @(negedge clk);
    accValid = 1'b1; accWrite = w; accChannel = ch; accDimm = dm; accRank = rk;
    accBank = bk; accPage = pg; accColumn = col;
    @(negedge clk);
    accValid = 1'b0;
    chk({tag, " pulse"}, 64'(injPulse), 64'(expHit));
    chk({tag, " ckFlip"}, 64'(ckFlip), expHit ? 64'(expCk) : 64'h0);
    chk({tag, " parFlip"}, 64'(parFlip), expHit ? 64'(expPar) : 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int expCount;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register and outputs
    for (int a = 0; a <= 10; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 reg%0d", a), 64'(d), 64'h0);
    end
    chk("R1 outputs", {45'h0, injPulse, parFlip, ckFlip}, 64'h0);

    // R2: readback with width limits
    wr(4'd0, 32'h8000_0003); rd(4'd0, d); chk("R2 chan", 64'(d), 64'h8000_0003);
    wr(4'd4, 32'h8003_ABCD); rd(4'd4, d); chk("R2 page", 64'(d), 64'h8000_ABCD);
    wr(4'd6, 32'h0000_01C3); rd(4'd6, d); chk("R2 mask", 64'(d), 64'hC3);
    wr(4'd8, 32'h0000_000F); rd(4'd8, d); chk("R2 kind", 64'(d), 64'h7);

    // table setup: ch==2, rank==0, page==A5, repeat+ecc, both halves, mask 41
    wr(4'd0, 32'h8000_0002);
    wr(4'd2, 32'h8000_0000);
    wr(4'd4, 32'h8000_00A5);
    wr(4'd6, 32'h0000_0041);
    wr(4'd7, 32'd3);
    wr(4'd8, 32'd3);

    // R9: disarmed block never injects
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b0, 16'h0, 2'b0, "R9 unarmed");

    wr(4'd9, 32'h0000_0100);
    rd(4'd9, d); chk("R9 armed", 64'(d), 64'h1);

    // R3 R4 R8: table walk in repeat mode
    expCount = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v;
      v = VEC[i];
      access(v[36], v[35:34], v[33:32], v[31:30], v[29:27], v[26:11], v[10:1], v[0],
             16'h4141, 2'b00, $sformatf("R3 vec%0d", i));
      if (v[0]) expCount++;
    end
    // R10: pulse lasts one cycle
    @(negedge clk);
    chk("R10 single cycle", 64'(injPulse), 64'h0);
    rd(4'd9, d);  chk("R8 still armed", 64'(d), 64'h1);
    rd(4'd10, d); chk("R11 count", 64'(d), 64'(expCount));

    // R9: disarm by writing zero
    wr(4'd9, 32'd0);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b0, 16'h0, 2'b0, "R9 disarmed");

    // R7 / R5: one-shot low half
    wr(4'd8, 32'd2); wr(4'd7, 32'd1); wr(4'd9, 32'd1);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b1, 16'h0041, 2'b0, "R5 low half");
    rd(4'd9, d); chk("R7 disarmed", 64'(d), 64'h0);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b0, 16'h0, 2'b0, "R7 no second");

    // R5: high half
    wr(4'd7, 32'd2); wr(4'd9, 32'd1);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b1, 16'h4100, 2'b0, "R5 high half");

    // R5: section 0 never injects and keeps arm
    wr(4'd7, 32'd0); wr(4'd9, 32'd1);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b0, 16'h0, 2'b0, "R5 section0");
    rd(4'd9, d); chk("R5 arm kept", 64'(d), 64'h1);

    // R6: parity only, upper section
    wr(4'd7, 32'd2); wr(4'd8, 32'd4);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b1, 16'h0, 2'b10, "R6 parity");

    // R6: neither kind bit -> no injection
    wr(4'd8, 32'd1); wr(4'd9, 32'd1);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b0, 16'h0, 2'b0, "R6 no kind");
    rd(4'd9, d); chk("R6 arm kept", 64'(d), 64'h1);

    // R6: combined ecc+parity both sections
    wr(4'd8, 32'd6); wr(4'd7, 32'd3);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b1, 16'h4141, 2'b11, "R6 combined");

    // R11: saturation after many repeat injections
    wr(4'd8, 32'd3); wr(4'd9, 32'd1);
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b1; accChannel = 2'd2; accRank = 2'd0; accPage = 16'h00A5;
    repeat (300) @(negedge clk);
    accValid = 1'b0;
    rd(4'd10, d); chk("R11 saturated", 64'(d), 64'hFF);
    access(1'b1, 2'd2, 2'd0, 2'd0, 3'd0, 16'h00A5, 10'd0, 1'b1, 16'h4141, 2'b0, "R11 after sat");
    rd(4'd10, d); chk("R11 held", 64'(d), 64'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule